// File: doc/BRIEF.md
# Paired Clock/Data Bit Serializer-Deserializer

This block sits between the separated bit streams of a disc read/write channel and a byte-wide microprocessor port. Each bit cell carries two bits side by side, a clock-position bit and a data-position bit, and the block handles both lanes in lockstep. On the read side it assembles the two serial lanes into a clock byte and a data byte. It places them in a holding register that the processor collects through two independent take strobes. On the write side the processor loads a clock byte and a data byte into a holding register. At each byte boundary the block moves them into shifters and sends them out one bit per cell, most significant bit first, toward the write encoder.

Bit cells are marked by a single-cycle strobe that both directions share. A processor that falls behind the disc is detected in both directions. On read, a byte that completes while the previous one is still uncollected is an overrun. On write, a byte boundary that arrives while the holding register is not fully loaded is an underrun. Either case sets one sticky status bit, which stays set until a clear strobe.

Top module: `cds_serdes`

## Requirements
- R1: After reset both holding registers, both serial write outputs, `rd_ready` and `sts_overrun` are 0, and `wr_need` is 1.
- R2: With `rd_en` high, each `bit_stb` shifts one bit into each read lane. The first bit of a byte lands in bit BYTE_W-1. On the cycle after the BYTE_W-th strobe, `rd_clk_byte`/`rd_dat_byte` show the assembled bytes and `rd_ready` is 1.
- R3: Cycles without `bit_stb` shift nothing and leave the read outputs and write serial outputs unchanged. Dropping `rd_en` discards a partially assembled read byte, and the next byte starts again at bit BYTE_W-1.
- R4: `rd_ready` stays 1 while either byte of the current pair is uncollected. `rd_take_clk` and `rd_take_dat` each mark their own byte collected. `rd_ready` falls once both have been taken.
- R5: A read byte that completes while either byte of the previous pair is still uncollected sets `sts_overrun`, and the new pair replaces the old. A take on the same cycle as the completing strobe counts as collected in time.
- R6: With `wr_en` high and the holding register full, the first strobe of a byte moves the pair into the shifters. After the k-th strobe of the byte (k = 1..BYTE_W), `wr_clk_bit`/`wr_dat_bit` equal bit BYTE_W-k of the loaded clock/data byte.
- R7: `wr_need` is 0 only when both `wr_load_clk` and `wr_load_dat` have filled the holding register since its last transfer. The transfer at a byte start makes `wr_need` 1 again. A load on the transfer cycle counts toward the next byte.
- R8: A byte-start strobe with the write holding register not full sets `sts_overrun`, and that byte goes out as all zeros on both lanes.
- R9: `sts_overrun` stays 1 until `sts_clr`. A new overrun or underrun on the same cycle as `sts_clr` leaves it at 1.
- R10: While `wr_en` is low, both serial write outputs are 0 and the bit position returns to the byte start. The write holding register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One-cycle pulse per bit cell |
| rd_en | input | 1 | Read path active |
| rd_clk_bit | input | 1 | Serial clock-position bit from the separator |
| rd_dat_bit | input | 1 | Serial data-position bit from the separator |
| rd_take_clk | input | 1 | Processor collects the clock byte |
| rd_take_dat | input | 1 | Processor collects the data byte |
| rd_clk_byte | output | BYTE_W | Assembled clock byte |
| rd_dat_byte | output | BYTE_W | Assembled data byte |
| rd_ready | output | 1 | An assembled pair is not yet fully collected |
| wr_en | input | 1 | Write path active |
| wr_load_clk | input | 1 | Load strobe for the clock byte |
| wr_load_dat | input | 1 | Load strobe for the data byte |
| wr_clk_byte | input | BYTE_W | Clock byte to write |
| wr_dat_byte | input | BYTE_W | Data byte to write |
| wr_need | output | 1 | Write holding register awaits a full pair |
| wr_clk_bit | output | 1 | Serial clock-position bit to the encoder |
| wr_dat_bit | output | 1 | Serial data-position bit to the encoder |
| sts_clr | input | 1 | Clears the overrun status |
| sts_overrun | output | 1 | Sticky overrun/underrun status |

## Verification
The bench builds the block with the default BYTE_W of 8. At that width, distinct clock and data patterns show MSB-first order in both directions, and a byte boundary falls every eight strobes. Gaps between strobes and a dropped enable mid-byte are exercised. Late service is provoked on both sides, along with the same-cycle corner cases: a take on the completing strobe, a load on the transfer strobe, and a clear against a new event.

// File: rtl/cds_pkg.sv
`timescale 1ns/1ps
// Package: shared lane indices and shifter direction selector for the
// paired clock/data serializer-deserializer.
package cds_pkg;
    localparam int LANES = 2;
    localparam int LANE_CLK = 0;
    localparam int LANE_DAT = 1;

    typedef enum logic {
        SHIFT_IN  = 1'b0,
        SHIFT_OUT = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/cds_bit_pos.sv
`timescale 1ns/1ps
// Module: cds_bit_pos
// Counts bit cells within a byte. Position 0 is the first cell of a byte.
// Assumes: stb is a single-cycle pulse; run low forces the byte start.
module cds_bit_pos #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stb,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    // Advance the position on each strobe, wrapping after the last cell.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos <= '0;
        end else if (stb) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/cds_lane_shift.sv
`timescale 1ns/1ps
// Module: cds_lane_shift
// One lane shifter, MSB first. DIR selects assembly (serial in, parallel out)
// or emission (parallel load, serial out).
// Assumes: BYTE_W >= 2; clr has priority over load and shift.
module cds_lane_shift
    import cds_pkg::*;
#(
    parameter int         BYTE_W = 8,
    parameter shift_dir_e DIR    = SHIFT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              ser_in,
    output logic [BYTE_W-1:0] par_out,
    output logic              ser_out
);
    logic [BYTE_W-1:0] sr;

    generate
        if (DIR == SHIFT_IN) begin : g_in
            // Assemble bits arriving MSB first.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    sr <= '0;
                end else if (shift) begin
                    sr <= {sr[BYTE_W-2:0], ser_in};
                end
            end
            // Present the byte including the bit arriving this cycle.
            assign par_out = {sr[BYTE_W-2:0], ser_in};
            assign ser_out = 1'b0;
            logic unused_in;
            assign unused_in = ^{load, load_val, sr[BYTE_W-1]};
        end else begin : g_out
            // Load a byte, then move it toward the MSB one cell at a time.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    sr <= '0;
                end else if (load) begin
                    sr <= load_val;
                end else if (shift) begin
                    sr <= {sr[BYTE_W-2:0], 1'b0};
                end
            end
            assign ser_out = sr[BYTE_W-1];
            assign par_out = sr;
            logic unused_out;
            assign unused_out = ser_in;
        end
    endgenerate
endmodule

// File: rtl/cds_rd_path.sv
`timescale 1ns/1ps
// Module: cds_rd_path
// Read side: assembles both lanes, keeps one holding pair with a per-lane
// collected flag, and reports late collection.
// Assumes: take strobes are single-cycle; takes of a collected byte are harmless.
module cds_rd_path
    import cds_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rd_en,
    input  logic [LANES-1:0]  ser_bits,
    input  logic [LANES-1:0]  take,
    output logic [BYTE_W-1:0] hold_clk,
    output logic [BYTE_W-1:0] hold_dat,
    output logic              ready,
    output logic              overrun_ev
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  pos;
    logic              step;
    logic              byte_done;
    logic [LANES-1:0]  unread;
    logic [LANES-1:0]  late;
    logic [BYTE_W-1:0] asm_byte [LANES];
    logic [BYTE_W-1:0] hold     [LANES];

    assign step      = rd_en && bit_stb;
    assign byte_done = step && (pos == LAST);

    cds_bit_pos #(.BYTE_W(BYTE_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rd_en),
        .stb   (bit_stb),
        .pos   (pos)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic lane_ser_unused;

            cds_lane_shift #(.BYTE_W(BYTE_W), .DIR(SHIFT_IN)) u_sh (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (!rd_en),
                .shift    (step),
                .load     (1'b0),
                .load_val ('0),
                .ser_in   (ser_bits[l]),
                .par_out  (asm_byte[l]),
                .ser_out  (lane_ser_unused)
            );

            // Capture the completed byte into this lane's holding register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold[l] <= '0;
                end else if (byte_done) begin
                    hold[l] <= asm_byte[l];
                end
            end

            // Track whether the processor still owes a take for this lane.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    unread[l] <= 1'b0;
                end else if (byte_done) begin
                    unread[l] <= 1'b1;
                end else if (take[l]) begin
                    unread[l] <= 1'b0;
                end
            end

            // A lane is late if its old byte is neither taken before nor now.
            assign late[l] = unread[l] && !take[l];
        end
    endgenerate

    assign hold_clk   = hold[LANE_CLK];
    assign hold_dat   = hold[LANE_DAT];
    assign ready      = |unread;
    assign overrun_ev = byte_done && (|late);
endmodule

// File: rtl/cds_wr_path.sv
`timescale 1ns/1ps
// Module: cds_wr_path
// Write side: one holding pair with per-lane full flags, transfer at each
// byte start, MSB-first emission on both lanes, underrun on an empty start.
// Assumes: a load of an already full lane overwrites it without error.
module cds_wr_path
    import cds_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              wr_en,
    input  logic [LANES-1:0]  load,
    input  logic [BYTE_W-1:0] byte_clk,
    input  logic [BYTE_W-1:0] byte_dat,
    output logic              need,
    output logic [LANES-1:0]  ser_bits,
    output logic              underrun_ev
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  pos;
    logic              step;
    logic              start;
    logic              pair_full;
    logic [LANES-1:0]  full;
    logic [BYTE_W-1:0] in_byte [LANES];
    logic [BYTE_W-1:0] hold    [LANES];

    assign step      = wr_en && bit_stb;
    assign start     = step && (pos == '0);
    assign pair_full = &full;
    assign in_byte[LANE_CLK] = byte_clk;
    assign in_byte[LANE_DAT] = byte_dat;

    cds_bit_pos #(.BYTE_W(BYTE_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wr_en),
        .stb   (bit_stb),
        .pos   (pos)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [BYTE_W-1:0] lane_par_unused;

            // Accept a processor byte into this lane's holding register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold[l] <= '0;
                end else if (load[l]) begin
                    hold[l] <= in_byte[l];
                end
            end

            // Full flag: emptied by a transfer, refilled by a later or same-cycle load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    full[l] <= 1'b0;
                end else begin
                    if (start && pair_full) begin
                        full[l] <= 1'b0;
                    end
                    if (load[l]) begin
                        full[l] <= 1'b1;
                    end
                end
            end

            cds_lane_shift #(.BYTE_W(BYTE_W), .DIR(SHIFT_OUT)) u_sh (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (!wr_en),
                .shift    (step && !start),
                .load     (start),
                .load_val (pair_full ? hold[l] : '0),
                .ser_in   (1'b0),
                .par_out  (lane_par_unused),
                .ser_out  (ser_bits[l])
            );
        end
    endgenerate

    assign need        = !pair_full;
    assign underrun_ev = start && !pair_full;
endmodule

// File: rtl/cds_status.sv
`timescale 1ns/1ps
// Module: cds_status
// Sticky late-service flag. Set by any event, cleared by a strobe;
// an event on the clearing cycle wins.
module cds_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_rd,
    input  logic set_wr,
    input  logic clr,
    output logic flag
);
    // Hold the flag until cleared; a simultaneous event keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_rd || set_wr) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cds_serdes.sv
`timescale 1ns/1ps
// Module: cds_serdes (top)
// Paired clock/data serializer-deserializer between separated disc bit
// streams and a byte-wide processor port, with a shared overrun status.
// Assumes: bit_stb marks one bit cell per pulse for whichever path is enabled.
module cds_serdes
    import cds_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rd_en,
    input  logic              rd_clk_bit,
    input  logic              rd_dat_bit,
    input  logic              rd_take_clk,
    input  logic              rd_take_dat,
    output logic [BYTE_W-1:0] rd_clk_byte,
    output logic [BYTE_W-1:0] rd_dat_byte,
    output logic              rd_ready,
    input  logic              wr_en,
    input  logic              wr_load_clk,
    input  logic              wr_load_dat,
    input  logic [BYTE_W-1:0] wr_clk_byte,
    input  logic [BYTE_W-1:0] wr_dat_byte,
    output logic              wr_need,
    output logic              wr_clk_bit,
    output logic              wr_dat_bit,
    input  logic              sts_clr,
    output logic              sts_overrun
);
    logic [LANES-1:0] rd_ser;
    logic [LANES-1:0] rd_take;
    logic [LANES-1:0] wr_load;
    logic [LANES-1:0] wr_ser;
    logic             rd_ovr_ev;
    logic             wr_und_ev;

    assign rd_ser[LANE_CLK]  = rd_clk_bit;
    assign rd_ser[LANE_DAT]  = rd_dat_bit;
    assign rd_take[LANE_CLK] = rd_take_clk;
    assign rd_take[LANE_DAT] = rd_take_dat;
    assign wr_load[LANE_CLK] = wr_load_clk;
    assign wr_load[LANE_DAT] = wr_load_dat;
    assign wr_clk_bit        = wr_ser[LANE_CLK];
    assign wr_dat_bit        = wr_ser[LANE_DAT];

    cds_rd_path #(.BYTE_W(BYTE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .rd_en      (rd_en),
        .ser_bits   (rd_ser),
        .take       (rd_take),
        .hold_clk   (rd_clk_byte),
        .hold_dat   (rd_dat_byte),
        .ready      (rd_ready),
        .overrun_ev (rd_ovr_ev)
    );

    cds_wr_path #(.BYTE_W(BYTE_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .wr_en       (wr_en),
        .load        (wr_load),
        .byte_clk    (wr_clk_byte),
        .byte_dat    (wr_dat_byte),
        .need        (wr_need),
        .ser_bits    (wr_ser),
        .underrun_ev (wr_und_ev)
    );

    cds_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_rd (rd_ovr_ev),
        .set_wr (wr_und_ev),
        .clr    (sts_clr),
        .flag   (sts_overrun)
    );
endmodule

// File: rtl/cds_serdes_chk.sv
`timescale 1ns/1ps
// Module: cds_serdes_chk
// Port-level temporal checks for cds_serdes, attached by bind.
module cds_serdes_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_stb,
    input logic              rd_en,
    input logic              rd_take_clk,
    input logic              rd_take_dat,
    input logic [BYTE_W-1:0] rd_clk_byte,
    input logic [BYTE_W-1:0] rd_dat_byte,
    input logic              rd_ready,
    input logic              wr_en,
    input logic              wr_load_clk,
    input logic              wr_load_dat,
    input logic              wr_need,
    input logic              wr_clk_bit,
    input logic              wr_dat_bit,
    input logic              sts_clr,
    input logic              sts_overrun
);
    AST_RD_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && bit_stb) |=> ($stable(rd_clk_byte) && $stable(rd_dat_byte))); // R3
    AST_WR_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bit_stb) |=> ($stable(wr_clk_bit) && $stable(wr_dat_bit))); // R3
    AST_RDY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && !rd_take_clk && !rd_take_dat) |=> rd_ready); // R4
    AST_RDY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take_clk && rd_take_dat && !(rd_en && bit_stb)) |=> !rd_ready); // R4
    AST_OVR_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_overrun) |-> $past(bit_stb)); // R5
    AST_NEED_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load_clk && wr_load_dat) |=> !wr_need); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_overrun && !sts_clr) |=> sts_overrun); // R9
    AST_WR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!wr_clk_bit && !wr_dat_bit)); // R10
endmodule

bind cds_serdes cds_serdes_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/cds_serdes_test.sv
`timescale 1ns/1ps
// Directed bench for cds_serdes: one task per scenario, each checking itself.
module cds_serdes_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_stb = 1'b0;
    logic         rd_en = 1'b0;
    logic         rd_clk_bit = 1'b0;
    logic         rd_dat_bit = 1'b0;
    logic         rd_take_clk = 1'b0;
    logic         rd_take_dat = 1'b0;
    logic [W-1:0] rd_clk_byte;
    logic [W-1:0] rd_dat_byte;
    logic         rd_ready;
    logic         wr_en = 1'b0;
    logic         wr_load_clk = 1'b0;
    logic         wr_load_dat = 1'b0;
    logic [W-1:0] wr_clk_byte = '0;
    logic [W-1:0] wr_dat_byte = '0;
    logic         wr_need;
    logic         wr_clk_bit;
    logic         wr_dat_bit;
    logic         sts_clr = 1'b0;
    logic         sts_overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cds_serdes #(.BYTE_W(W)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    // Feed one byte pair, MSB first; optionally take on the last strobe.
    task automatic feed(input logic [W-1:0] c, input logic [W-1:0] d, input bit take_last);
        for (int i = W - 1; i >= 0; i--) begin
            rd_clk_bit = c[i];
            rd_dat_bit = d[i];
            if (i == 0 && take_last) begin
                rd_take_clk = 1'b1;
                rd_take_dat = 1'b1;
            end
            strobe();
            rd_take_clk = 1'b0;
            rd_take_dat = 1'b0;
        end
    endtask

    task automatic take_both();
        rd_take_clk = 1'b1;
        rd_take_dat = 1'b1;
        @(negedge clk);
        rd_take_clk = 1'b0;
        rd_take_dat = 1'b0;
    endtask

    task automatic clear_sts();
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic load_pair(input logic [W-1:0] c, input logic [W-1:0] d);
        wr_clk_byte = c;
        wr_dat_byte = d;
        wr_load_clk = 1'b1;
        wr_load_dat = 1'b1;
        @(negedge clk);
        wr_load_clk = 1'b0;
        wr_load_dat = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_clk_byte", rd_clk_byte, 0);
        check("R1 rd_dat_byte", rd_dat_byte, 0);
        check("R1 rd_ready", rd_ready, 0);
        check("R1 wr_need", wr_need, 1);
        check("R1 wr bits", {wr_clk_bit, wr_dat_bit}, 0);
        check("R1 sts_overrun", sts_overrun, 0);
    endtask

    task automatic t_read_basic();
        rd_en = 1'b1;
        feed(8'hA5, 8'h3C, 1'b0);
        check("R2 clock byte", rd_clk_byte, 8'hA5);
        check("R2 data byte", rd_dat_byte, 8'h3C);
        check("R2 ready", rd_ready, 1);
        take_both();
        check("R4 ready after both takes", rd_ready, 0);
    endtask

    task automatic t_read_gaps_restart();
        // three stray bits, then rd_en drops: partial byte discarded
        rd_clk_bit = 1'b1; rd_dat_bit = 1'b1;
        strobe(); strobe(); strobe();
        rd_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            rd_clk_bit = ~i[0];
            rd_dat_bit = i[1];
            strobe();
            rd_clk_bit = 1'b1; rd_dat_bit = 1'b0;
            idle(2);
        end
        check("R3 restart+gaps clock byte", rd_clk_byte, 8'h55);
        check("R3 restart+gaps data byte", rd_dat_byte, 8'hCC);
        check("R3 no overrun", sts_overrun, 0);
    endtask

    task automatic t_read_two_ports();
        rd_take_clk = 1'b1;
        @(negedge clk);
        rd_take_clk = 1'b0;
        check("R4 ready with data untaken", rd_ready, 1);
        rd_take_dat = 1'b1;
        @(negedge clk);
        rd_take_dat = 1'b0;
        check("R4 ready after data take", rd_ready, 0);
    endtask

    task automatic t_read_overrun();
        feed(8'h11, 8'h22, 1'b0);
        check("R5 no overrun on first", sts_overrun, 0);
        feed(8'h81, 8'h7E, 1'b0);
        check("R5 overrun set", sts_overrun, 1);
        check("R5 new clock byte", rd_clk_byte, 8'h81);
        check("R5 new data byte", rd_dat_byte, 8'h7E);
        take_both();
        clear_sts();
        check("R9 cleared", sts_overrun, 0);
        // take coinciding with completion is in time
        feed(8'hF0, 8'h0F, 1'b0);
        feed(8'h96, 8'h69, 1'b1);
        check("R5 same-cycle take no overrun", sts_overrun, 0);
        check("R5 same-cycle take ready", rd_ready, 1);
        check("R5 same-cycle byte", rd_clk_byte, 8'h96);
        take_both();
        rd_en = 1'b0;
    endtask

    task automatic t_write_stream();
        load_pair(8'hB4, 8'h5A);
        check("R7 need low when full", wr_need, 0);
        wr_en = 1'b1;
        for (int k = W - 1; k >= 0; k--) begin
            if (k == 0) load_pair(8'hC3, 8'h18);   // next pair, off-strobe
            if (k == W - 2) begin
                // load on a non-start strobe counts toward the next byte too
            end
            strobe();
            check("R6 clock bit", wr_clk_bit, (8'hB4 >> k) & 1);
            check("R6 data bit", wr_dat_bit, (8'h5A >> k) & 1);
            if (k == W - 1) check("R7 need after transfer", wr_need, 1);
        end
        // second byte: load on the transfer cycle itself counts for the third
        wr_clk_byte = 8'h01; wr_dat_byte = 8'h80;
        wr_load_clk = 1'b1; wr_load_dat = 1'b1;
        strobe();
        wr_load_clk = 1'b0; wr_load_dat = 1'b0;
        check("R6 second byte MSB", {wr_clk_bit, wr_dat_bit}, 2'b10);
        check("R7 same-cycle load kept", wr_need, 0);
        for (int k = W - 2; k >= 0; k--) strobe();
        check("R6 second byte LSB", {wr_clk_bit, wr_dat_bit}, 2'b10);
        check("R8 no underrun yet", sts_overrun, 0);
        for (int k = W - 1; k >= 0; k--) begin
            strobe();
            check("R6 third byte", {wr_clk_bit, wr_dat_bit}, {1'(8'h01 >> k), 1'(8'h80 >> k)});
        end
    endtask

    task automatic t_write_underrun();
        wr_load_clk = 1'b1;   // only half the pair
        wr_clk_byte = 8'hFF;
        @(negedge clk);
        wr_load_clk = 1'b0;
        check("R7 need with half pair", wr_need, 1);
        strobe();
        check("R8 underrun set", sts_overrun, 1);
        check("R8 zero bits", {wr_clk_bit, wr_dat_bit}, 0);
        for (int k = W - 2; k >= 0; k--) strobe();
        check("R8 zeros through byte", {wr_clk_bit, wr_dat_bit}, 0);
        idle(3);
        check("R9 sticky over idle", sts_overrun, 1);
    endtask

    task automatic t_idle_and_clear();
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 outputs zero", {wr_clk_bit, wr_dat_bit}, 0);
        check("R10 holding kept", wr_need, 1);
        // event coincides with clear: still set
        wr_en = 1'b1;
        sts_clr = 1'b1;
        strobe();
        sts_clr = 1'b0;
        check("R9 event beats clear", sts_overrun, 1);
        wr_en = 1'b0;
        clear_sts();
        check("R9 clear alone", sts_overrun, 0);
        // restart position: full pair after wr_en toggle starts at MSB
        wr_dat_byte = 8'h40;
        wr_load_dat = 1'b1;
        @(negedge clk);
        wr_load_dat = 1'b0;
        check("R7 need low after second half", wr_need, 0);
        wr_en = 1'b1;
        strobe();
        check("R10 restart at MSB", {wr_clk_bit, wr_dat_bit}, 2'b10);
        strobe();
        check("R10 second bit", {wr_clk_bit, wr_dat_bit}, 2'b11);
        check("R10 no underrun", sts_overrun, 0);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_read_gaps_restart();
        t_read_two_ports();
        t_read_overrun();
        t_write_stream();
        t_write_underrun();
        t_idle_and_clear();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule